// File: doc/BRIEF.md
# Mesochronous Sample Bridge FIFO

This block carries a stream of converter samples from the clock forwarded by the converter into the main system clock domain. The two clocks run at the same frequency. Their phase relationship is unknown and wanders slowly within a bounded range. Storage is a shallow register array. The write and read pointers are Gray coded and one bit wider than the address. Each pointer crosses to the other domain through a two-flop synchronizer.

The write side accepts a sample on every cycle that its enable is high. The read side has no stall input. After reset it waits for the first sign that data is present. It then counts a programmable number of further read-clock cycles before it starts reading. From then on it reads on every read cycle. The entries built up during that wait absorb the pointer-synchronizer latency and the phase wander, so the output stream has no gaps.

If the FIFO ever runs dry, a sticky flag records the event and the read side repeats the prefill wait. If a write arrives while the FIFO is full, the sample is dropped and a sticky flag records it.

Top module: `meso_bridge_fifo`

## Requirements
- R1: While the read reset is asserted, `rd_valid` and `rd_underflow` are 0. While the write reset is asserted, `wr_overflow` is 0.
- R2: Every sample accepted on the write side appears exactly once on `rd_data`, in write order, in a cycle where `rd_valid` is 1.
- R3: Reading waits for the FIFO to be seen non-empty and then for PREFILL more read cycles. If the FIFO already holds data when the read reset is released, the first `rd_valid` is seen after the (PREFILL+4)th rising read-clock edge and not before it. During a continuous write stream, at least PREFILL+1 samples have been written before the first output.
- R4: Once output has started, `rd_valid` stays 1 on every read cycle for as long as the writer keeps writing every cycle. This holds even while the phase offset between the clocks drifts.
- R5: A write while the FIFO holds DEPTH entries is dropped and sets `wr_overflow`, which stays 1 until write reset. Exactly DEPTH writes into an undrained FIFO do not set it.
- R6: If the FIFO is empty during a read cycle after output has started, `rd_valid` drops and `rd_underflow` is set and stays 1 until read reset. The read side then repeats the prefill wait and resumes with the next sample written.
- R7: The Gray-coded pointers that cross the clock boundary change by at most one bit per cycle of their own clock.
- R8: DEPTH is a power of two, PREFILL is at least 1, and DEPTH is greater than twice PREFILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Forwarded converter clock (write domain) |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_en | input | 1 | Write a sample this cycle |
| wr_data | input | DATA_W | Sample to write |
| wr_overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |
| rd_clk | input | 1 | System clock (read domain) |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_data | output | DATA_W | Sample delivered this cycle |
| rd_valid | output | 1 | `rd_data` holds a sample |
| rd_underflow | output | 1 | Sticky: the FIFO ran dry while output was running |

## Verification
Several internal faults show up at the ports. A read pointer that skips or repeats an entry shows within one output cycle as a break in the counting sequence on `rd_data`. A wrong full compare corrupts or loses data within DEPTH writes when the reader is held in reset. A prefill counter that is off by one moves the first `rd_valid` by exactly one read edge. A prefill that is too short shows as a dropped `rd_valid` or a raised `rd_underflow` within a few cycles of startup while the phase sweeps. A pointer encoding that is not single-bit-step would corrupt the synchronized pointer and produce lost or repeated samples in the long drifting-phase run.

// File: rtl/meso_pkg.sv
package meso_pkg;

    // Read-side sequencing: wait for data, count the prefill margin, then stream.
    typedef enum logic [1:0] {
        RD_WAIT = 2'd0,
        RD_FILL = 2'd1,
        RD_RUN  = 2'd2
    } rd_mode_e;

endpackage

// File: rtl/meso_sync.sv
module meso_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;

endmodule

// File: rtl/meso_store.sv
module meso_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AW     = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/meso_wr_side.sv
module meso_wr_side #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_sync,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          overflow
);

    localparam logic [PW-1:0] FULL_COUNT = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic          ovf;
    } wr_state_t;

    wr_state_t st_d, st_q;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] r;
        r[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) r[i] = r[i+1] ^ g[i];
        return r;
    endfunction

    logic [PW-1:0] rbin_seen;
    logic [PW-1:0] used;
    logic          full;

    always_comb begin
        rbin_seen = from_gray(rgray_sync);
        used      = st_q.wbin - rbin_seen;
        full      = (used == FULL_COUNT);
        push      = wr_en && !full;

        st_d = st_q;
        if (push) st_d.wbin = st_q.wbin + 1'b1;
        st_d.wgray = to_gray(st_d.wbin);
        if (wr_en && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr    = st_q.wbin[AW-1:0];
    assign wgray    = st_q.wgray;
    assign overflow = st_q.ovf;

    // R7: the pointer that crosses to the read domain moves by one bit at most
    a_r7_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);

    // R5: a write against a full FIFO leaves the write pointer where it was
    a_r5_full_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(st_q.wbin));

    // R5: overflow indication is sticky
    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

endmodule

// File: rtl/meso_rd_side.sv
module meso_rd_side
    import meso_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int AW      = 4,
    parameter int PW      = AW + 1,
    parameter int PREFILL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              underflow
);

    localparam int CW = $clog2(PREFILL + 1);
    localparam logic [CW-1:0] LAST_WAIT = CW'(PREFILL - 1);

    typedef struct packed {
        rd_mode_e          mode;
        logic [CW-1:0]     cnt;
        logic [PW-1:0]     rbin;
        logic [PW-1:0]     rgray;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              unf;
    } rd_state_t;

    rd_state_t st_d, st_q;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] r;
        r[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) r[i] = r[i+1] ^ g[i];
        return r;
    endfunction

    logic [PW-1:0] wbin_seen;
    logic          empty;

    always_comb begin
        wbin_seen = from_gray(wgray_sync);
        empty     = (wbin_seen == st_q.rbin);

        st_d       = st_q;
        st_d.valid = 1'b0;

        unique case (st_q.mode)
            RD_WAIT: begin
                if (!empty) begin
                    st_d.mode = RD_FILL;
                    st_d.cnt  = '0;
                end
            end
            RD_FILL: begin
                if (st_q.cnt == LAST_WAIT) st_d.mode = RD_RUN;
                else                       st_d.cnt  = st_q.cnt + 1'b1;
            end
            RD_RUN: begin
                if (empty) begin
                    st_d.unf  = 1'b1;
                    st_d.mode = RD_WAIT;
                end else begin
                    st_d.rbin  = st_q.rbin + 1'b1;
                    st_d.data  = mem_rdata;
                    st_d.valid = 1'b1;
                end
            end
            default: st_d.mode = RD_WAIT;
        endcase

        st_d.rgray = to_gray(st_d.rbin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= RD_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr     = st_q.rbin[AW-1:0];
    assign rgray     = st_q.rgray;
    assign rd_data   = st_q.data;
    assign rd_valid  = st_q.valid;
    assign underflow = st_q.unf;

    // R7: the pointer that crosses to the write domain moves by one bit at most
    a_r7_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.rgray ^ $past(st_q.rgray)) <= 1);

    // R3: nothing is delivered while waiting or prefilling
    a_r3_quiet_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != RD_RUN) |=> !st_q.valid);

    // R2: an empty FIFO never yields a sample
    a_r2_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !st_q.valid);

    // R6: underflow indication is sticky
    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf |=> st_q.unf);

    // R6: running dry returns the sequencer to the wait state
    a_r6_restart_prefill: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == RD_RUN && empty) |=> (st_q.mode == RD_WAIT));

endmodule

// File: rtl/meso_bridge_fifo.sv
module meso_bridge_fifo #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 16,
    parameter int PREFILL = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    // R8: configuration limits
    initial begin
        a_r8_config: assert ((DEPTH == (1 << AW)) && (PREFILL >= 1) && (DEPTH > 2 * PREFILL))
            else $error("meso_bridge_fifo: DEPTH must be a power of two above 2*PREFILL, PREFILL >= 1");
    end

    logic              push;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_in_rd;
    logic [PW-1:0]     rgray_in_wr;
    logic [DATA_W-1:0] mem_rdata;

    meso_wr_side #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .PW    (PW)
    ) wr_side_i (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .wr_en      (wr_en),
        .rgray_sync (rgray_in_wr),
        .push       (push),
        .waddr      (waddr),
        .wgray      (wgray),
        .overflow   (wr_overflow)
    );

    meso_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) store_i (
        .wr_clk (wr_clk),
        .we     (push),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    meso_sync #(.W(PW)) w2r_sync_i (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_in_rd)
    );

    meso_sync #(.W(PW)) r2w_sync_i (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_in_wr)
    );

    meso_rd_side #(
        .DATA_W  (DATA_W),
        .AW      (AW),
        .PW      (PW),
        .PREFILL (PREFILL)
    ) rd_side_i (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .wgray_sync (wgray_in_rd),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .underflow  (rd_underflow)
    );

endmodule

// File: tb/meso_bridge_fifo_tb_top.sv
`timescale 1ns/1ps
module meso_bridge_fifo_tb_top;

    localparam int DATA_W  = 16;
    localparam int DEPTH   = 16;
    localparam int PREFILL = 4;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_overflow;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              rd_underflow;

    meso_bridge_fifo #(
        .DATA_W  (DATA_W),
        .DEPTH   (DEPTH),
        .PREFILL (PREFILL)
    ) dut_i (
        .wr_clk       (wr_clk),
        .wr_rst_n     (wr_rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_overflow  (wr_overflow),
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_underflow (rd_underflow)
    );

    // write clock: 100 MHz
    always #5.0 wr_clk = ~wr_clk;

    // read clock: same nominal period; phase offset sweeps 0 -> 4 ns -> 0 in 0.25 ns steps
    real phase_ns = 0.0;
    real step_ns  = 0.25;
    initial begin
        #1.3;
        forever begin
            for (int k = 0; k < 8; k++) begin
                rd_clk = 1'b1;
                #5.0;
                rd_clk = 1'b0;
                if (k == 0) begin
                    if (phase_ns >= 4.0)      step_ns = -0.25;
                    else if (phase_ns <= 0.0) step_ns = 0.25;
                    phase_ns = phase_ns + step_ns;
                    #(5.0 + step_ns);
                end else begin
                    #5.0;
                end
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // output monitor
    bit mon_en  = 1'b0;
    bit mon_gap = 1'b0;
    bit started = 1'b0;
    int exp_next = 0;
    int got = 0;
    int wcnt = 0;
    int wcnt_at_first = -1;

    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (rd_valid) begin
                check(int'(rd_data) == (exp_next & 16'hFFFF), "R2 order", int'(rd_data), exp_next & 16'hFFFF);
                if (!started && wcnt_at_first < 0) wcnt_at_first = wcnt;
                exp_next++;
                got++;
                started = 1'b1;
            end else if (started && mon_gap) begin
                check(1'b0, "R4 gap in output", 0, 1);
            end
        end
    end

    task automatic write_n(input int start, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = DATA_W'(start + i);
            wcnt++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        // ---------------- reset state (R1)
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1'b0,     "R1 rd_valid in reset",     int'(rd_valid), 0);
        check(rd_underflow == 1'b0, "R1 rd_underflow in reset", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0,  "R1 wr_overflow in reset",  int'(wr_overflow), 0);

        // ---------------- phase 1: long continuous stream under phase drift (R2, R3, R4)
        @(negedge wr_clk); wr_rst_n = 1'b1;
        @(negedge rd_clk); rd_rst_n = 1'b1;
        mon_en = 1'b1; mon_gap = 1'b1; started = 1'b0;
        exp_next = 0; got = 0; wcnt = 0; wcnt_at_first = -1;
        write_n(0, 3000);
        check(rd_underflow == 1'b0, "R4 no underflow while streaming", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0,  "R5 no overflow while streaming",  int'(wr_overflow), 0);
        mon_gap = 1'b0;
        repeat (30) @(negedge rd_clk);
        check(got == 3000, "R2 lossless count", got, 3000);
        check(wcnt_at_first >= PREFILL + 1, "R3 prefill depth before first output", wcnt_at_first, PREFILL + 1);
        check(rd_underflow == 1'b1, "R6 underflow after writer stops", int'(rd_underflow), 1);
        check(rd_valid == 1'b0,     "R6 valid drops when dry",         int'(rd_valid), 0);

        // ---------------- phase 2: fill with reader held in reset (R5)
        mon_en = 1'b0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        check(rd_underflow == 1'b0, "R1 underflow cleared by reset", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0,  "R1 overflow cleared by reset",  int'(wr_overflow), 0);
        @(negedge wr_clk); wr_rst_n = 1'b1;
        repeat (4) @(negedge wr_clk);
        write_n(0, DEPTH);
        repeat (4) @(negedge wr_clk);
        check(wr_overflow == 1'b0, "R5 exactly DEPTH writes", int'(wr_overflow), 0);
        write_n(DEPTH, 3);
        repeat (2) @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R5 write while full", int'(wr_overflow), 1);

        // ---------------- phase 2: precise prefill timing on release (R3)
        exp_next = 0; got = 0; started = 1'b0; wcnt_at_first = -1;
        mon_en = 1'b1; mon_gap = 1'b1;
        @(negedge rd_clk); rd_rst_n = 1'b1;
        repeat (PREFILL + 3) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R3 no output before edge PREFILL+4", int'(rd_valid), 0);
        @(negedge rd_clk);
        check(rd_valid == 1'b1, "R3 first output at edge PREFILL+4", int'(rd_valid), 1);
        check(int'(rd_data) == 0, "R3 first sample value", int'(rd_data), 0);
        repeat (DEPTH - 2) @(negedge rd_clk);
        mon_gap = 1'b0;
        repeat (30) @(negedge rd_clk);
        check(got == DEPTH, "R5 dropped writes absent", got, DEPTH);
        check(rd_underflow == 1'b1, "R6 underflow after drain", int'(rd_underflow), 1);
        check(rd_valid == 1'b0, "R6 valid low after drain", int'(rd_valid), 0);
        check(wr_overflow == 1'b1, "R5 overflow sticky", int'(wr_overflow), 1);

        // ---------------- restart after underflow (R6)
        exp_next = 100; started = 1'b0; mon_gap = 1'b1;
        write_n(100, 200);
        mon_gap = 1'b0;
        repeat (30) @(negedge rd_clk);
        check(got == DEPTH + 200, "R6 stream resumes after prefill", got, DEPTH + 200);
        check(rd_underflow == 1'b1, "R6 underflow stays set", int'(rd_underflow), 1);

        finish_run();
    end

endmodule